// File: doc/BRIEF.md
# GPIO Port Register Bank

This block is the register side of an 8-bit general-purpose I/O port. It holds three writable registers (output latch, input inversion mask and pin direction) and one read-only view of the pin levels. A bus controller outside the block decodes the serial protocol. It hands the block a register select, a write strobe with a data byte, and a read capture strobe. The block answers with a captured read byte and drives per-pin output-enable and output-value signals toward the pad ring. The pin levels arrive already synchronized.

Every pin starts as an input. Software turns a pin into a driven output by clearing its direction bit, and the latch bit then sets the level that is driven. The input view always shows the level of every pin, whatever its direction. That level is exclusive-ORed with the inversion mask. Reads of the three writable registers return their stored contents. The read byte is captured into a holding register when the controller asks for it, so it stays still while it is shifted out.

Top module: `gpio_port_bank`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the latch register reads 0xFF, the inversion register reads 0x00 and the direction register reads 0xFF. pad_oe, pad_out and rd_data are all 0.
- R2: reg_sel selects a register by code: 0 is the pin view, 1 is the output latch, 2 is the inversion mask and 3 is the direction register. A write to codes 1 to 3 stores wr_data, and a later read of the same code returns it.
- R3: Direction bit i at 1 makes pin i an input, with pad_oe[i] at 0. Direction bit i at 0 makes pin i an output, with pad_oe[i] at 1.
- R4: pad_out[i] equals latch bit i on an output pin. On an input pin it is 0, whatever the latch holds.
- R5: A read of code 1 returns the stored latch value, not the pin level.
- R6: A read of code 0 returns pin_in XOR the inversion mask for all pins, including pins set as outputs.
- R7: A write to code 0 changes no register and no pad signal.
- R8: rd_data loads the selected value at the clock edge where rd_sample is 1, and it appears in the following cycle. With rd_sample at 0, rd_data holds its value even when pin_in or the registers change.
- R9: A reset asserted in mid operation restores every default from R1.
- R10: A write to code 1 or code 3 shows on pad_out and pad_oe right after the clock edge that samples the write strobe, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_sel | input | 2 | Register code for a write or a read capture |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| wr_data | input | 8 | Byte to write |
| rd_sample | input | 1 | Capture the selected register into rd_data |
| pin_in | input | 8 | Synchronized pin levels |
| rd_data | output | 8 | Captured read byte |
| pad_oe | output | 8 | Per-pin output enable toward the pads |
| pad_out | output | 8 | Per-pin driven level toward the pads |

## Verification
A wrong value in the latch or direction flops shows on pad_out or pad_oe right after the clock edge that writes it. It also shows in the read byte one cycle after a capture. A fault in the inversion mask stays hidden until a capture of the pin view, and it then appears as a bit-wise mismatch against pin_in. For that reason the pin view is swept over all 256 pin patterns under several masks and a mixed direction setting. A missing hold on the capture register shows as soon as the pins move between two captures.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int SEL_W    = 2;
  localparam int NUM_REGS = 4;

  typedef enum logic [SEL_W-1:0] {
    SEL_PINS   = 2'd0,
    SEL_LATCH  = 2'd1,
    SEL_INVERT = 2'd2,
    SEL_DIR    = 2'd3
  } gpio_sel_e;
endpackage

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
  import gpio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  gpio_sel_e    wr_sel,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] latch_q,
  output logic [W-1:0] invert_q,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] latch_d,
  output logic [W-1:0] dir_d
);
  logic [W-1:0] cur_q [1:NUM_REGS-1];
  logic [W-1:0] nxt   [1:NUM_REGS-1];

  for (genvar r = 1; r < NUM_REGS; r++) begin : g_reg
    localparam logic [W-1:0] RST_VAL = (r == int'(SEL_INVERT)) ? '0 : '1;
    logic hit;
    assign hit    = wr_en && (wr_sel == gpio_sel_e'(r));
    assign nxt[r] = hit ? wr_data : cur_q[r];
    always_ff @(posedge clk) begin
      if (!rst_n) cur_q[r] <= RST_VAL;
      else        cur_q[r] <= nxt[r];
    end
  end

  assign latch_q  = cur_q[SEL_LATCH];
  assign invert_q = cur_q[SEL_INVERT];
  assign dir_q    = cur_q[SEL_DIR];
  assign latch_d  = nxt[SEL_LATCH];
  assign dir_d    = nxt[SEL_DIR];

  // R7: writing the pin view leaves every stored register untouched
  p_pin_view_readonly_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_PINS) |=> ($stable(latch_q) && $stable(invert_q) && $stable(dir_q)));
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] latch_d,
  input  logic [W-1:0] dir_d,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_out
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pad_oe[i]  <= 1'b0;
        pad_out[i] <= 1'b0;
      end else begin
        pad_oe[i]  <= ~dir_d[i];
        pad_out[i] <= latch_d[i] & ~dir_d[i];
      end
    end
  end

  // R4: a pin that is not driven never shows a driven-high level
  p_input_pin_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out & ~pad_oe) == '0));
endmodule

// File: rtl/gpio_read_path.sv
module gpio_read_path
  import gpio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sample,
  input  gpio_sel_e    sel,
  input  logic [W-1:0] pin_in,
  input  logic [W-1:0] latch_q,
  input  logic [W-1:0] invert_q,
  input  logic [W-1:0] dir_q,
  output logic [W-1:0] rd_data
);
  logic [W-1:0] mux_val;

  always_comb begin
    unique case (sel)
      SEL_PINS:   mux_val = pin_in ^ invert_q;
      SEL_LATCH:  mux_val = latch_q;
      SEL_INVERT: mux_val = invert_q;
      default:    mux_val = dir_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rd_data <= '0;
    else if (sample) rd_data <= mux_val;
  end

  // R8: the captured byte holds while no capture is requested
  p_capture_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sample |=> $stable(rd_data));
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
  import gpio_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       reg_sel,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_sample,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] rd_data,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_out
);
  gpio_sel_e        sel;
  logic [WIDTH-1:0] latch_q, invert_q, dir_q, latch_d, dir_d;

  assign sel = gpio_sel_e'(reg_sel);

  gpio_ctrl_regs #(.W(WIDTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(sel), .wr_data(wr_data),
    .latch_q(latch_q), .invert_q(invert_q), .dir_q(dir_q),
    .latch_d(latch_d), .dir_d(dir_d)
  );

  gpio_pad_drive #(.W(WIDTH)) u_pads (
    .clk(clk), .rst_n(rst_n), .latch_d(latch_d), .dir_d(dir_d),
    .pad_oe(pad_oe), .pad_out(pad_out)
  );

  gpio_read_path #(.W(WIDTH)) u_read (
    .clk(clk), .rst_n(rst_n), .sample(rd_sample), .sel(sel), .pin_in(pin_in),
    .latch_q(latch_q), .invert_q(invert_q), .dir_q(dir_q), .rd_data(rd_data)
  );

  // R1 / R9: a reset edge clears every port-visible output
  p_reset_defaults_r1: assert property (@(posedge clk)
    !rst_n |=> (pad_oe == '0 && pad_out == '0 && rd_data == '0));

  // R3: a direction write sets the output enables on the next edge
  p_dir_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == 2'd3) |=> (pad_oe == ~$past(wr_data)));

  // R10: a latch write reaches the enabled pads on the next edge
  p_latch_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == 2'd1) |=> (pad_out == ($past(wr_data) & pad_oe)));
endmodule

// File: tb/test_gpio_port_bank.sv
`timescale 1ns/1ps
module test_gpio_port_bank;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_sample = 1'b0;
  logic [7:0] pin_in = 8'h00;
  logic [7:0] rd_data, pad_oe, pad_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [7:0] m_latch, m_inv, m_dir;

  always #2 clk = ~clk;

  gpio_port_bank #(.WIDTH(8)) i_gpio_port_bank (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .wr_data(wr_data),
    .rd_sample(rd_sample), .pin_in(pin_in), .rd_data(rd_data),
    .pad_oe(pad_oe), .pad_out(pad_out)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    reg_sel = s; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    case (s)
      2'd1: m_latch = d;
      2'd2: m_inv = d;
      2'd3: m_dir = d;
      default: ;
    endcase
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] v);
    @(negedge clk);
    reg_sel = s; rd_sample = 1'b1;
    @(negedge clk);
    rd_sample = 1'b0;
    v = rd_data;
  endtask

  task automatic check_pads(input string req);
    chk({req, " pad_oe"}, pad_oe, ~m_dir);
    chk({req, " pad_out"}, pad_out, m_latch & ~m_dir);
  endtask

  task automatic check_defaults(input string req);
    logic [7:0] v;
    rd(2'd1, v); chk({req, " latch default"}, v, 8'hFF);
    rd(2'd2, v); chk({req, " invert default"}, v, 8'h00);
    rd(2'd3, v); chk({req, " dir default"}, v, 8'hFF);
    chk({req, " pad_oe default"}, pad_oe, 8'h00);
    chk({req, " pad_out default"}, pad_out, 8'h00);
  endtask

  initial begin
    logic [7:0] v, held;
    m_latch = 8'hFF; m_inv = 8'h00; m_dir = 8'hFF;
    repeat (3) @(negedge clk);
    // R1: outputs while reset is held, then register defaults
    chk("R1 rd_data in reset", rd_data, 8'h00);
    chk("R1 pad_oe in reset", pad_oe, 8'h00);
    chk("R1 pad_out in reset", pad_out, 8'h00);
    rst_n = 1'b1;
    check_defaults("R1");

    // R2 R3 R4 R5: sweep every byte through each writable register
    wr(2'd1, 8'hA5);
    for (int k = 0; k < 256; k++) begin
      wr(2'd3, 8'(k));
      check_pads("R3 R4");
      rd(2'd3, v); chk("R2 dir readback", v, 8'(k));
      wr(2'd2, 8'(k));
      rd(2'd2, v); chk("R2 invert readback", v, 8'(k));
    end
    wr(2'd3, 8'h00);
    for (int k = 0; k < 256; k++) begin
      pin_in = ~8'(k);
      wr(2'd1, 8'(k));
      chk("R4 pad_out all outputs", pad_out, 8'(k));
      rd(2'd1, v); chk("R5 latch not pin", v, 8'(k));
    end

    // R6: pin view under a mixed direction setting and several masks
    wr(2'd3, 8'h0F);
    wr(2'd1, 8'h3C);
    for (int m = 0; m < 4; m++) begin
      logic [7:0] mask;
      mask = (m == 0) ? 8'h00 : (m == 1) ? 8'hFF : (m == 2) ? 8'h3C : 8'h81;
      wr(2'd2, mask);
      for (int p = 0; p < 256; p++) begin
        pin_in = 8'(p);
        rd(2'd0, v);
        chk("R6 pin view", v, 8'(p) ^ mask);
      end
    end

    // R7: writing the pin view changes nothing
    wr(2'd0, 8'h5A);
    check_pads("R7");
    rd(2'd1, v); chk("R7 latch kept", v, 8'h3C);
    rd(2'd2, v); chk("R7 invert kept", v, 8'h81);
    rd(2'd3, v); chk("R7 dir kept", v, 8'h0F);

    // R8: captured byte holds while pins and registers move
    wr(2'd2, 8'h00);
    pin_in = 8'h96;
    rd(2'd0, held);
    chk("R8 capture", held, 8'h96);
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      pin_in = 8'(c * 37);
      chk("R8 hold", rd_data, 8'h96);
    end
    wr(2'd1, 8'h11);
    chk("R8 hold across write", rd_data, 8'h96);

    // R10: pads change only after the edge that samples the strobe
    wr(2'd3, 8'h00);
    @(negedge clk);
    reg_sel = 2'd1; wr_data = 8'hC3; wr_en = 1'b1;
    #1;
    chk("R10 before edge", pad_out, 8'h11);
    @(negedge clk);
    wr_en = 1'b0; m_latch = 8'hC3;
    chk("R10 after edge", pad_out, 8'hC3);
    @(negedge clk);
    reg_sel = 2'd3; wr_data = 8'hF0; wr_en = 1'b1;
    #1;
    chk("R10 oe before edge", pad_oe, 8'hFF);
    @(negedge clk);
    wr_en = 1'b0; m_dir = 8'hF0;
    chk("R10 oe after edge", pad_oe, 8'h0F);
    check_pads("R10");

    // R9: reset in mid operation
    wr(2'd2, 8'h77);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    m_latch = 8'hFF; m_inv = 8'h00; m_dir = 8'hFF;
    check_defaults("R9");
    pin_in = 8'h5C;
    rd(2'd0, v); chk("R9 no inversion after reset", v, 8'h5C);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule